// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single internal transfer requests into external bus cycles on a 16-line shared address/data bus. The strobes on that bus are active low: address latch, chip select and byte-high enable. A direction output and an active-low wait input complete the bus. The requester gives an address, write data, a read/write flag and a byte/word flag. The block then runs the whole cycle by itself. When the cycle ends it returns the read data, if any, and raises a one-clock completion strobe.

Each cycle has five phases, in this order:

1. Address latch.
2. Address hold.
3. Data setup.
4. Strobe.
5. Data hold.

Each phase lasts its programmed count plus one clock, so every timing value is a number of clocks. A slave can stretch the strobe phase by pulling the wait input low. The slave may be 8 bits or 16 bits wide. In 16-bit mode, single bytes are selected with byte-high enable and address bit 0. Pad tristate control is brought out as an output-enable for the shared lines.

Top module: `adbus_master`

## Requirements
- R1: While reset is high and on the first clock after it, the latch, select and byte-high outputs are 1, the output-enable is 0, and busy and done are 0.
- R2: When configuration bit 0 (enable) is 0, requests are ignored: busy stays 0 and latch and select stay high.
- R3: Phase 1 drives latch low with the address on the lines and the output-enable at 1 for (config bits 3:2)+1 clocks. Latch and select are never low together.
- R4: Phase 2 raises latch and keeps the address driven for (config bits 5:4)+1 clocks.
- R5: Phase 3 lasts (config bits 14:13)+1 clocks. It drives the write data on a write, and drops the output-enable on a read.
- R6: With wait high, phase 4 holds select low for (config bits 12:7)+1 clocks. The valid range of that field is 0 to 62.
- R7: The wait input passes through two synchronizing flops. Each strobe-phase clock that sees a low synchronized wait adds one clock. If wait is low before phase 4 and goes high in its (M+1)-th clock, select stays low for (config bits 12:7)+3+M clocks.
- R8: Phase 5 keeps write data driven for (config bit 6)+1 clocks. Then done is high for exactly one clock, and busy falls in that same clock.
- R9: Read data is taken from the lines on the clock edge at which select returns high, and is presented on the read-data output from then on.
- R10: With config bit 1 at 0 (8-bit mode), lines 7:0 carry data, lines 15:8 are driven 0 in the data phases, byte-high enable is 1, and reads return lines 7:0 zero-extended.
- R11: With config bit 1 at 1 (16-bit mode), word transfers have byte-high enable at 0 and use all lines. Byte transfers with address bit 0 at 0 have byte-high enable at 1 and use lines 7:0. Byte transfers with address bit 0 at 1 have byte-high enable at 0 and use lines 15:8. A byte write drives its byte on both halves, and a byte read returns its lane zero-extended.
- R12: The direction output (1 = write) and byte-high enable do not change from acceptance to completion.
- R13: A request is accepted only while idle. Busy is high from the clock after acceptance until the done clock, and requests made while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 16 | Configuration: enable, width mode, phase counts |
| req_valid_i | input | 1 | Request pulse, taken only when idle and enabled |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | 1 = byte transfer, 0 = word |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 16 | Write data (byte in bits 7:0) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion strobe |
| rdata_o | output | 16 | Read data captured at strobe end |
| bus_ad_o | output | 16 | Value driven on shared lines |
| bus_ad_oe_o | output | 1 | Drive enable for shared lines |
| bus_ad_i | input | 16 | Value seen on shared lines |
| bus_ale_n_o | output | 1 | Address latch, active low |
| bus_cs_n_o | output | 1 | Chip select strobe, active low |
| bus_dir_o | output | 1 | Direction, 1 = write |
| bus_bhe_n_o | output | 1 | Byte-high enable, active low |
| bus_wait_n_i | input | 1 | Slave wait request, active low |

## Verification
The bench sweeps every combination of the three 2-bit phase counts and the data-hold bit against two strobe counts. It varies direction, width mode, byte/word and address bit 0 along the way, and measures each phase length clock by clock. An off-by-one in any phase counter, or a counter that restarts wrongly between phases, shows up as a length one clock off. Wait extension is tested with a known release point. A design without the synchronizer delay, or one that counts stalled clocks, gives a strobe that is too short. Lane steering is tested with byte writes and reads at both address parities in both modes. Swapped halves or a wrong byte-high value show up as wrong line values or wrong read data. Requests are also injected while the block is disabled and while a cycle is running. A design that starts a cycle or restarts mid-cycle in those cases shows up as busy or an extra cycle.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_SETUP,
    ST_STROBE,
    ST_DHOLD
  } phase_e;

  typedef struct packed {
    logic             en;
    logic             wide;
    logic [1:0]       t_addr;
    logic [1:0]       t_ahold;
    logic [1:0]       t_setup;
    logic [CNT_W-1:0] t_strobe;
    logic             t_dhold;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [15:0] r);
    cfg_t c;
    c.en       = r[0];
    c.wide     = r[1];
    c.t_addr   = r[3:2];
    c.t_ahold  = r[5:4];
    c.t_dhold  = r[6];
    c.t_strobe = r[12:7];
    c.t_setup  = r[14:13];
    return c;
  endfunction

endpackage

// File: rtl/adbus_wait_sync.sv
module adbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_n_i,
  output logic wait_act_o
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk) begin
    if (rst) sq[0] <= 1'b1;
    else     sq[0] <= wait_n_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sq[i] <= 1'b1;
        else     sq[i] <= sq[i-1];
      end
    end
  endgenerate

  assign wait_act_o = ~sq[STAGES-1];
endmodule

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cfg_t   cfg,
  input  logic   req_valid,
  input  logic   wait_act,
  output phase_e st_q,
  output phase_e st_d,
  output logic   accept,
  output logic   strobe_end,
  output logic   finish
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  phase_e           st_next;

  always_comb begin
    limit   = '0;
    st_next = ST_IDLE;
    unique case (st_q)
      ST_ADDR:   begin limit = CNT_W'(cfg.t_addr);  st_next = ST_AHOLD;  end
      ST_AHOLD:  begin limit = CNT_W'(cfg.t_ahold); st_next = ST_SETUP;  end
      ST_SETUP:  begin limit = CNT_W'(cfg.t_setup); st_next = ST_STROBE; end
      ST_STROBE: begin limit = cfg.t_strobe;        st_next = ST_DHOLD;  end
      ST_DHOLD:  begin limit = CNT_W'(cfg.t_dhold); st_next = ST_IDLE;   end
      default:   begin limit = '0;                  st_next = ST_IDLE;   end
    endcase
  end

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    accept     = 1'b0;
    strobe_end = 1'b0;
    finish     = 1'b0;
    if (st_q == ST_IDLE) begin
      if (req_valid && cfg.en) begin
        accept = 1'b1;
        st_d   = ST_ADDR;
        cnt_d  = '0;
      end
    end else if (st_q == ST_STROBE && wait_act) begin
      cnt_d = cnt_q;
    end else if (cnt_q == limit) begin
      st_d       = st_next;
      cnt_d      = '0;
      strobe_end = (st_q == ST_STROBE);
      finish     = (st_q == ST_DHOLD);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/adbus_lane.sv
module adbus_lane #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic          byte_sel,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] drive,
  output logic [DW-1:0] rdata,
  output logic          bhe_n
);
  localparam int HALF = DW / 2;

  always_comb begin
    if (!wide) begin
      drive = {{HALF{1'b0}}, wdata[HALF-1:0]};
      rdata = {{HALF{1'b0}}, ad_in[HALF-1:0]};
      bhe_n = 1'b1;
    end else if (byte_sel) begin
      drive = {wdata[HALF-1:0], wdata[HALF-1:0]};
      rdata = a0 ? {{HALF{1'b0}}, ad_in[DW-1:HALF]}
                 : {{HALF{1'b0}}, ad_in[HALF-1:0]};
      bhe_n = ~a0;
    end else begin
      drive = wdata;
      rdata = ad_in;
      bhe_n = 1'b0;
    end
  end
endmodule

// File: rtl/adbus_master.sv
module adbus_master
  import adbus_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   cfg_i,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          req_byte_i,
  input  logic [DW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe_o,
  input  logic [DW-1:0] bus_ad_i,
  output logic          bus_ale_n_o,
  output logic          bus_cs_n_o,
  output logic          bus_dir_o,
  output logic          bus_bhe_n_o,
  input  logic          bus_wait_n_i
);
  cfg_t   cfg;
  phase_e st_q, st_d;
  logic   accept, strobe_end, finish, wait_act;

  logic          wr_q, byte_q, wide_q;
  logic [DW-1:0] addr_q, wdata_q;
  logic          cur_wr, cur_byte, cur_wide;
  logic [DW-1:0] cur_addr, cur_wdata;
  logic [DW-1:0] lane_drive, lane_rdata;
  logic          lane_bhe_n;

  assign cfg = unpack_cfg(cfg_i);

  adbus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .wait_n_i(bus_wait_n_i), .wait_act_o(wait_act)
  );

  adbus_seq u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .req_valid(req_valid_i),
    .wait_act(wait_act), .st_q(st_q), .st_d(st_d), .accept(accept),
    .strobe_end(strobe_end), .finish(finish)
  );

  assign cur_wr    = accept ? req_write_i : wr_q;
  assign cur_byte  = accept ? req_byte_i  : byte_q;
  assign cur_wide  = accept ? cfg.wide    : wide_q;
  assign cur_addr  = accept ? req_addr_i  : addr_q;
  assign cur_wdata = accept ? req_wdata_i : wdata_q;

  adbus_lane #(.DW(DW)) u_lane (
    .wide(cur_wide), .byte_sel(cur_byte), .a0(cur_addr[0]),
    .wdata(cur_wdata), .ad_in(bus_ad_i),
    .drive(lane_drive), .rdata(lane_rdata), .bhe_n(lane_bhe_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0; byte_q <= 1'b0; wide_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
      busy_o <= 1'b0; done_o <= 1'b0; rdata_o <= '0;
      bus_ad_o <= '0; bus_ad_oe_o <= 1'b0;
      bus_ale_n_o <= 1'b1; bus_cs_n_o <= 1'b1;
      bus_dir_o <= 1'b0; bus_bhe_n_o <= 1'b1;
    end else begin
      if (accept) begin
        wr_q <= req_write_i; byte_q <= req_byte_i; wide_q <= cfg.wide;
        addr_q <= req_addr_i; wdata_q <= req_wdata_i;
        bus_dir_o   <= req_write_i;
        bus_bhe_n_o <= lane_bhe_n;
      end
      busy_o <= (st_d != ST_IDLE);
      done_o <= finish;
      if (strobe_end && !wr_q) rdata_o <= lane_rdata;
      unique case (st_d)
        ST_ADDR: begin
          bus_ale_n_o <= 1'b0; bus_cs_n_o <= 1'b1;
          bus_ad_o <= cur_addr; bus_ad_oe_o <= 1'b1;
        end
        ST_AHOLD: begin
          bus_ale_n_o <= 1'b1; bus_cs_n_o <= 1'b1;
          bus_ad_o <= cur_addr; bus_ad_oe_o <= 1'b1;
        end
        ST_SETUP, ST_DHOLD: begin
          bus_ale_n_o <= 1'b1; bus_cs_n_o <= 1'b1;
          bus_ad_o <= cur_wr ? lane_drive : '0; bus_ad_oe_o <= cur_wr;
        end
        ST_STROBE: begin
          bus_ale_n_o <= 1'b1; bus_cs_n_o <= 1'b0;
          bus_ad_o <= cur_wr ? lane_drive : '0; bus_ad_oe_o <= cur_wr;
        end
        default: begin
          bus_ale_n_o <= 1'b1; bus_cs_n_o <= 1'b1;
          bus_ad_o <= '0; bus_ad_oe_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adbus_master_chk.sv
module adbus_master_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cfg_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        bus_ad_oe_o,
  input logic        bus_ale_n_o,
  input logic        bus_cs_n_o,
  input logic        bus_dir_o,
  input logic        bus_bhe_n_o
);
  assert_ale_cs_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(!bus_ale_n_o && !bus_cs_n_o));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (bus_ale_n_o && bus_cs_n_o && !bus_ad_oe_o));

  assert_disabled_no_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !cfg_i[0]) |=> !busy_o);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n_o && !bus_dir_o) |-> !bus_ad_oe_o);

  assert_dir_bhe_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(bus_dir_o) && $stable(bus_bhe_n_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_busy_ends_on_done_R13: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind adbus_master adbus_master_chk u_chk (
  .clk(clk), .rst(rst), .cfg_i(cfg_i), .busy_o(busy_o), .done_o(done_o),
  .bus_ad_oe_o(bus_ad_oe_o), .bus_ale_n_o(bus_ale_n_o), .bus_cs_n_o(bus_cs_n_o),
  .bus_dir_o(bus_dir_o), .bus_bhe_n_o(bus_bhe_n_o)
);

// File: tb/test_adbus_master.sv
`timescale 1ns/1ps
module test_adbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_i = '0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_byte_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic        busy_o, done_o;
  logic [15:0] rdata_o, bus_ad_o;
  logic        bus_ad_oe_o;
  logic [15:0] bus_ad_i = '0;
  logic        bus_ale_n_o, bus_cs_n_o, bus_dir_o, bus_bhe_n_o;
  logic        bus_wait_n_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adbus_master i_adbus_master (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_byte_i(req_byte_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o), .bus_ad_i(bus_ad_i),
    .bus_ale_n_o(bus_ale_n_o), .bus_cs_n_o(bus_cs_n_o), .bus_dir_o(bus_dir_o),
    .bus_bhe_n_o(bus_bhe_n_o), .bus_wait_n_i(bus_wait_n_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input bit en, input bit wide, input int ta,
      input int th, input int ts, input int tp, input int td);
    return {1'b0, 2'(ts), 6'(tp), 1'(td), 2'(th), 2'(ta), wide, en};
  endfunction

  // wait_m < 0: no wait; otherwise wait low before strobe, released in strobe clock wait_m+1
  task automatic run_txn(input bit wide, input int ta, input int th, input int ts,
      input int tp, input int td, input bit wr, input bit bsel, input logic [15:0] addr,
      input logic [15:0] wdata, input logic [15:0] slave, input int wait_m, input bit poke);
    int na = 0, nh = 0, ns = 0, nc = 0, nd = 0, guard = 0;
    bit bad_a = 0, bad_h = 0, bad_s = 0, bad_c = 0, bad_d = 0, bad_st = 0, ended = 0;
    logic [15:0] exp_drv, exp_rd;
    logic exp_bhe;
    if (!wide) begin
      exp_drv = {8'h00, wdata[7:0]}; exp_rd = {8'h00, slave[7:0]}; exp_bhe = 1'b1;
    end else if (bsel) begin
      exp_drv = {wdata[7:0], wdata[7:0]};
      exp_rd  = addr[0] ? {8'h00, slave[15:8]} : {8'h00, slave[7:0]};
      exp_bhe = ~addr[0];
    end else begin
      exp_drv = wdata; exp_rd = slave; exp_bhe = 1'b0;
    end
    cfg_i = mk_cfg(1'b1, wide, ta, th, ts, tp, td);
    bus_ad_i = slave;
    if (wait_m >= 0) bus_wait_n_i = 1'b0;
    req_write_i = wr; req_byte_i = bsel; req_addr_i = addr; req_wdata_i = wdata;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!ended && guard < 600) begin
      guard++;
      if (bus_ale_n_o == 1'b0) begin
        na++;
        if (bus_ad_o !== addr || bus_ad_oe_o !== 1'b1 || bus_cs_n_o !== 1'b1) bad_a = 1;
      end else if (bus_cs_n_o == 1'b0) begin
        nc++;
        if (wr ? (bus_ad_o !== exp_drv || bus_ad_oe_o !== 1'b1) : (bus_ad_oe_o !== 1'b0)) bad_c = 1;
        if (wait_m >= 0 && nc == wait_m + 1) bus_wait_n_i = 1'b1;
      end else if (busy_o && nc == 0 && bus_ad_oe_o && bus_ad_o[15]) begin
        nh++;
        if (bus_ad_o !== addr) bad_h = 1;
        if (poke && nh == 1) begin
          req_addr_i = 16'h8123; req_valid_i = 1'b1;
        end
      end else if (busy_o && nc == 0) begin
        ns++;
        if (wr ? (bus_ad_o !== exp_drv || bus_ad_oe_o !== 1'b1) : (bus_ad_oe_o !== 1'b0)) bad_s = 1;
      end else if (busy_o) begin
        nd++;
        if (wr ? (bus_ad_o !== exp_drv || bus_ad_oe_o !== 1'b1) : (bus_ad_oe_o !== 1'b0)) bad_d = 1;
      end else begin
        ended = 1;
      end
      if (!ended && (bus_dir_o !== wr || bus_bhe_n_o !== exp_bhe)) bad_st = 1;
      if (!ended) begin
        @(negedge clk);
        req_valid_i = 1'b0;
      end
    end
    check(ended, "R13 cycle completes", guard, 0);
    check(na == ta + 1 && !bad_a, "R3 address phase", na, ta + 1);
    check(nh == th + 1 && !bad_h, "R4 address hold", nh, th + 1);
    check(ns == ts + 1 && !bad_s, "R5 data setup", ns, ts + 1);
    if (wait_m < 0) check(nc == tp + 1 && !bad_c, "R6 strobe length", nc, tp + 1);
    else            check(nc == tp + 3 + wait_m && !bad_c, "R7 wait extension", nc, tp + 3 + wait_m);
    check(nd == td + 1 && !bad_d, "R8 data hold", nd, td + 1);
    check(!bad_st, "R12 dir/bhe stable", bus_bhe_n_o, exp_bhe);
    check(done_o === 1'b1 && busy_o === 1'b0, "R8 done strobe", done_o, 1);
    if (!wr) begin
      if (!wide) check(rdata_o === exp_rd, "R10 8-bit read", rdata_o, exp_rd);
      else       check(rdata_o === exp_rd, "R9 R11 read capture", rdata_o, exp_rd);
    end
    @(negedge clk);
    check(done_o === 1'b0, "R8 done single clock", done_o, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy_o === 1'b0 && bus_ale_n_o === 1'b1, "R13 request while busy dropped", busy_o, 0);
    end
    bus_wait_n_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bus_ale_n_o === 1 && bus_cs_n_o === 1 && bus_bhe_n_o === 1 && bus_ad_oe_o === 0
          && busy_o === 0 && done_o === 0, "R1 reset state", {bus_ale_n_o, bus_cs_n_o, busy_o}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    check(bus_ale_n_o === 1 && bus_cs_n_o === 1 && busy_o === 0, "R1 after reset", busy_o, 0);

    // R2: disabled, request ignored
    cfg_i = mk_cfg(1'b0, 1'b1, 0, 0, 0, 0, 0);
    req_addr_i = 16'h8001; req_valid_i = 1'b1;
    begin
      bit bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (busy_o !== 1'b0 || bus_ale_n_o !== 1'b1 || bus_cs_n_o !== 1'b1) bad = 1;
      end
      check(!bad, "R2 disabled ignores requests", busy_o, 0);
    end
    req_valid_i = 1'b0;
    @(negedge clk);

    // Sweep of phase counts, direction, width, byte lanes
    for (int ta = 0; ta < 4; ta++)
      for (int th = 0; th < 4; th++)
        for (int ts = 0; ts < 4; ts++)
          for (int td = 0; td < 2; td++)
            for (int k = 0; k < 2; k++) begin
              int idx = ta * 32 + th * 8 + ts * 2 + td + k;
              bit wr = idx[0];
              bit wide = idx[1] | idx[3];
              bit bsel = idx[2];
              logic [15:0] addr = 16'h8000 | 16'(idx * 37) | 16'(idx[4]);
              logic [15:0] wd = 16'h0000 | 16'(idx * 211) & 16'h7F7F;
              logic [15:0] sv = 16'hA55A ^ 16'(idx * 97);
              run_txn(wide, ta, th, ts, (k == 0) ? 0 : 3, td, wr, bsel, addr, wd, sv, -1, 1'b0);
            end

    // R11: explicit lane cases in 16-bit mode
    run_txn(1'b1, 0, 0, 0, 1, 0, 1'b1, 1'b1, 16'h8010, 16'h0042, 16'h0000, -1, 1'b0);
    run_txn(1'b1, 0, 0, 0, 1, 0, 1'b1, 1'b1, 16'h8011, 16'h0037, 16'h0000, -1, 1'b0);
    run_txn(1'b1, 0, 0, 0, 1, 0, 1'b0, 1'b1, 16'h8021, 16'h0000, 16'hBE11, -1, 1'b0);
    run_txn(1'b1, 0, 0, 0, 1, 0, 1'b0, 1'b1, 16'h8020, 16'h0000, 16'hBE11, -1, 1'b0);
    run_txn(1'b1, 0, 0, 0, 1, 0, 1'b1, 1'b0, 16'h8030, 16'h1234, 16'h0000, -1, 1'b0);
    // R10: 8-bit mode
    run_txn(1'b0, 1, 0, 1, 2, 1, 1'b1, 1'b1, 16'h8041, 16'h5566, 16'h0000, -1, 1'b0);
    run_txn(1'b0, 1, 0, 1, 2, 1, 1'b0, 1'b0, 16'h8041, 16'h0000, 16'hC3D4, -1, 1'b0);
    // R6: maximum strobe count
    run_txn(1'b1, 0, 0, 0, 62, 0, 1'b0, 1'b0, 16'h8050, 16'h0000, 16'h7E81, -1, 1'b0);
    // R7: wait extension
    run_txn(1'b1, 0, 1, 0, 2, 0, 1'b0, 1'b0, 16'h8060, 16'h0000, 16'h2468, 0, 1'b0);
    run_txn(1'b1, 0, 1, 0, 2, 0, 1'b1, 1'b0, 16'h8061, 16'h0135, 16'h0000, 4, 1'b0);
    run_txn(1'b1, 1, 0, 0, 0, 1, 1'b0, 1'b0, 16'h8062, 16'h0000, 16'h1357, 9, 1'b0);
    // R13: request while busy
    run_txn(1'b1, 0, 1, 0, 1, 0, 1'b1, 1'b0, 16'h8070, 16'h0246, 16'h0000, -1, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule